// File: doc/BRIEF.md
# Glitch-Tolerant Video Timing Regenerator

This block rebuilds frame and line timing for a camera link whose frame-valid travels over a noisy contact. It runs on a locally maintained pixel-rate clock and sees only the raw, possibly glitchy, frame-valid level. A two-flop synchroniser feeds a qualifier. The qualifier accepts a rising edge only after the synchronised level has stayed high for a programmable number of clocks. The first accepted edge after reset arms the block. From then on, frame-valid, line-valid and a pixel enable come purely from counters, so every frame carries the configured number of lines and every line the configured number of pixels, whatever the input does.

Each line is a horizontal blanking stretch followed by the active pixels. Each frame is the active lines followed by the vertical blanking lines. The four counts are runtime inputs, captured only when a frame begins. An optional resync mode lets an accepted input edge restart the frame. This happens only when the edge lands within a small window around the expected frame boundary, and that window lies entirely in blanking. An edge seen while armed outside that window raises a one-cycle status pulse.

Top module: `vid_timing_regen`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to the unarmed state. After that edge `armed`, `fv_out`, `lv_out`, `px_en` and `edge_miss` are all 0.
- R2: If `fv_raw` is sampled high on `cfg_qual`+1 consecutive clock edges, the edge is accepted. Counting the first high sample as edge 1, an unarmed block sets `armed` at edge `cfg_qual`+3, and the first line of a new frame begins in the cycle that follows.
- R3: A high pulse on `fv_raw` that is sampled on fewer than `cfg_qual`+1 consecutive edges is never accepted and leaves an unarmed block unarmed.
- R4: Every line lasts `cfg_hblank`+`cfg_act_px` clocks. `lv_out` is low for the first `cfg_hblank` clocks of an active line and high for the remaining `cfg_act_px`. `px_en` equals `lv_out` on every cycle.
- R5: Every frame lasts `cfg_act_ln`+`cfg_vblank` lines. `fv_out` is high for all clocks of the first `cfg_act_ln` lines and low for the rest.
- R6: The four count inputs are captured only when a frame begins (at arming, at a natural frame wrap, or at a resync restart). A change in the middle of a frame takes effect at the next frame.
- R7: With `resync_en` low, accepted edges after arming never alter the timing.
- R8: With `resync_en` high, an accepted edge restarts the frame in the next cycle if it is processed in one of two places. The first is the last blanking line (`cfg_vblank` captured non-zero) at a line position at or beyond the line length minus 1 minus `cfg_window`. The second is line 0 at a position below both `cfg_window` and the captured `cfg_hblank`. An edge at the exact expected boundary leaves the timing unchanged.
- R9: `edge_miss` pulses for exactly one cycle, the cycle after an accepted edge that arrives while armed outside the R8 window. This happens whether or not `resync_en` is set.
- R10: `lv_out` is never high while `fv_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| fv_raw | input | 1 | Raw, unsynchronised incoming frame-valid |
| resync_en | input | 1 | Allow in-window realignment to the input |
| cfg_qual | input | QUAL_W | Extra high clocks required before an edge is accepted |
| cfg_window | input | WIN_W | Half-width of the realignment window in clocks |
| cfg_act_px | input | CNT_W | Active pixels per line |
| cfg_hblank | input | CNT_W | Blanking clocks at the start of each line |
| cfg_act_ln | input | CNT_W | Active lines per frame |
| cfg_vblank | input | CNT_W | Blanking lines at the end of each frame |
| fv_out | output | 1 | Regenerated frame-valid |
| lv_out | output | 1 | Regenerated line-valid |
| px_en | output | 1 | Pixel enable, high on active pixels |
| armed | output | 1 | Counters are running |
| edge_miss | output | 1 | One-cycle pulse: accepted edge outside the window |

## Verification
The hardest state to reach from the ports is an accepted input edge that lands on a chosen counter position. This matters most at the two edges of the realignment window, because the qualifier and synchroniser put `cfg_qual`+2 clocks between a raw transition and the cycle that acts on it. The bench keeps its own behavioural model of the line and frame position. It raises `fv_raw` exactly `cfg_qual`+2 positions ahead of the target. This lets it aim shots at early-in-window, late-in-window, on-time and out-of-window spots. A bench-side count of `edge_miss` pulses then confirms which shots were judged inside the window.

// File: rtl/vtr_pkg.sv
`timescale 1ns/1ps
package vtr_pkg;

   // Where an accepted edge falls relative to the expected frame boundary.
   typedef enum logic [1:0] {
      POS_OUTSIDE = 2'd0,
      POS_EARLY   = 2'd1,
      POS_LATE    = 2'd2
   } win_pos_e;

   function automatic int unsigned vtr_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/vtr_edge_qual.sv
`timescale 1ns/1ps
module vtr_edge_qual #(
   parameter int QUAL_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fv_raw,
   input  logic [QUAL_W-1:0] cfg_qual,
   output logic              acc_edge
);
   localparam int HW = QUAL_W + 1;

   logic          meta_q;
   logic          sync_q;
   logic [HW-1:0] high_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         meta_q   <= 1'b0;
         sync_q   <= 1'b0;
         high_run <= '0;
      end else begin
         meta_q <= fv_raw;
         sync_q <= meta_q;
         if (!sync_q)
            high_run <= '0;
         else if (high_run != '1)
            high_run <= high_run + 1'b1;
      end
   end

   // The run counter is one bit wider than the threshold, so it always
   // passes the threshold once and never parks on it.
   assign acc_edge = sync_q && (high_run == {1'b0, cfg_qual});

   a_r3_single_accept: assert property (@(posedge clk) disable iff (rst)
      acc_edge |=> !acc_edge);

endmodule

// File: rtl/vtr_frame_ctr.sv
`timescale 1ns/1ps
module vtr_frame_ctr #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] cfg_act_px,
   input  logic [CNT_W-1:0] cfg_hblank,
   input  logic [CNT_W-1:0] cfg_act_ln,
   input  logic [CNT_W-1:0] cfg_vblank,
   output logic             running,
   output logic [CNT_W:0]   hcnt,
   output logic [CNT_W:0]   vcnt,
   output logic [CNT_W:0]   h_last,
   output logic [CNT_W:0]   v_last,
   output logic [CNT_W-1:0] lat_hb,
   output logic [CNT_W-1:0] lat_vb,
   output logic             fv,
   output logic             lv
);
   localparam int TW = CNT_W + 1;

   logic [CNT_W-1:0] lat_px;
   logic [CNT_W-1:0] lat_ln;
   logic             end_line;
   logic             end_frame;

   always_comb begin
      h_last    = TW'(lat_hb) + TW'(lat_px) - 1'b1;
      v_last    = TW'(lat_ln) + TW'(lat_vb) - 1'b1;
      end_line  = (hcnt == h_last);
      end_frame = end_line && (vcnt == v_last);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         running <= 1'b0;
         hcnt    <= '0;
         vcnt    <= '0;
         lat_px  <= '0;
         lat_hb  <= '0;
         lat_ln  <= '0;
         lat_vb  <= '0;
      end else if (load || (running && end_frame)) begin
         running <= 1'b1;
         hcnt    <= '0;
         vcnt    <= '0;
         lat_px  <= cfg_act_px;
         lat_hb  <= cfg_hblank;
         lat_ln  <= cfg_act_ln;
         lat_vb  <= cfg_vblank;
      end else if (running) begin
         if (end_line) begin
            hcnt <= '0;
            vcnt <= vcnt + 1'b1;
         end else begin
            hcnt <= hcnt + 1'b1;
         end
      end
   end

   assign fv = running && (vcnt < TW'(lat_ln));
   assign lv = fv && (hcnt >= TW'(lat_hb));

   a_r4_h_bound: assert property (@(posedge clk) disable iff (rst)
      running |-> (hcnt <= h_last));

   a_r4_step: assert property (@(posedge clk) disable iff (rst)
      (running && !load && !end_line) |=> (hcnt == $past(hcnt) + 1'b1));

   a_r6_hold_cfg: assert property (@(posedge clk) disable iff (rst)
      (running && !load && !end_frame) |=> ($stable(lat_px) && $stable(lat_ln)));

endmodule

// File: rtl/vtr_window.sv
`timescale 1ns/1ps
module vtr_window
   import vtr_pkg::*;
#(
   parameter int CNT_W = 12,
   parameter int WIN_W = 4
) (
   input  logic [CNT_W:0]   hcnt,
   input  logic [CNT_W:0]   vcnt,
   input  logic [CNT_W:0]   h_last,
   input  logic [CNT_W:0]   v_last,
   input  logic [CNT_W-1:0] lat_hb,
   input  logic [CNT_W-1:0] lat_vb,
   input  logic [WIN_W-1:0] win,
   output logic             in_win
);
   localparam int SW = int'(vtr_max(CNT_W, WIN_W)) + 2;

   logic [SW-1:0] h_x, w_x, last_x, hb_x;
   win_pos_e      pos;

   always_comb begin
      h_x    = SW'(hcnt);
      w_x    = SW'(win);
      last_x = SW'(h_last);
      hb_x   = SW'(lat_hb);
      pos    = POS_OUTSIDE;
      // Early side: tail of the final blanking line.
      if ((lat_vb != '0) && (vcnt == v_last) && (h_x + w_x >= last_x))
         pos = POS_EARLY;
      // Late side: head of line 0, kept inside horizontal blanking.
      else if ((vcnt == '0) && (h_x < w_x) && (h_x < hb_x))
         pos = POS_LATE;
      in_win = (pos != POS_OUTSIDE);
   end

endmodule

// File: rtl/vid_timing_regen.sv
`timescale 1ns/1ps
module vid_timing_regen #(
   parameter int CNT_W      = 12,
   parameter int QUAL_W     = 4,
   parameter int WIN_W      = 4,
   parameter bit HAS_RESYNC = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fv_raw,
   input  logic              resync_en,
   input  logic [QUAL_W-1:0] cfg_qual,
   input  logic [WIN_W-1:0]  cfg_window,
   input  logic [CNT_W-1:0]  cfg_act_px,
   input  logic [CNT_W-1:0]  cfg_hblank,
   input  logic [CNT_W-1:0]  cfg_act_ln,
   input  logic [CNT_W-1:0]  cfg_vblank,
   output logic              fv_out,
   output logic              lv_out,
   output logic              px_en,
   output logic              armed,
   output logic              edge_miss
);
   if (CNT_W < 2 || CNT_W > 24) begin : g_bad_cnt
      $error("CNT_W must lie in 2..24");
   end
   if (QUAL_W < 1 || QUAL_W > 16) begin : g_bad_qual
      $error("QUAL_W must lie in 1..16");
   end
   if (WIN_W < 1 || WIN_W > CNT_W) begin : g_bad_win
      $error("WIN_W must lie in 1..CNT_W");
   end

   logic             acc_edge;
   logic             in_win;
   logic             load;
   logic [CNT_W:0]   hcnt, vcnt, h_last, v_last;
   logic [CNT_W-1:0] lat_hb, lat_vb;
   logic             fv_i, lv_i;
   logic             miss_q;

   vtr_edge_qual #(.QUAL_W(QUAL_W)) u_qual (
      .clk      (clk),
      .rst      (rst),
      .fv_raw   (fv_raw),
      .cfg_qual (cfg_qual),
      .acc_edge (acc_edge)
   );

   vtr_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk        (clk),
      .rst        (rst),
      .load       (load),
      .cfg_act_px (cfg_act_px),
      .cfg_hblank (cfg_hblank),
      .cfg_act_ln (cfg_act_ln),
      .cfg_vblank (cfg_vblank),
      .running    (armed),
      .hcnt       (hcnt),
      .vcnt       (vcnt),
      .h_last     (h_last),
      .v_last     (v_last),
      .lat_hb     (lat_hb),
      .lat_vb     (lat_vb),
      .fv         (fv_i),
      .lv         (lv_i)
   );

   if (HAS_RESYNC) begin : g_win
      vtr_window #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_win (
         .hcnt   (hcnt),
         .vcnt   (vcnt),
         .h_last (h_last),
         .v_last (v_last),
         .lat_hb (lat_hb),
         .lat_vb (lat_vb),
         .win    (cfg_window),
         .in_win (in_win)
      );
      assign load = acc_edge && (!armed || (resync_en && in_win));
   end else begin : g_nowin
      assign in_win = 1'b1;
      assign load   = acc_edge && !armed;
   end

   always_ff @(posedge clk) begin
      if (rst) miss_q <= 1'b0;
      else     miss_q <= armed && acc_edge && !in_win;
   end

   assign fv_out    = fv_i;
   assign lv_out    = lv_i;
   assign px_en     = lv_i;
   assign edge_miss = miss_q;

   a_r1_reset_idle: assert property (@(posedge clk)
      rst |=> (!armed && !fv_out && !lv_out && !edge_miss));

   a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
      (armed && !resync_en && !((hcnt == h_last) && (vcnt == v_last)))
      |=> !((hcnt == '0) && (vcnt == '0)));

   a_r9_miss_armed: assert property (@(posedge clk) disable iff (rst)
      edge_miss |-> $past(armed));

endmodule

// File: tb/vid_timing_regen_tb.sv
`timescale 1ns/1ps
module vid_timing_regen_tb;
   localparam int CW = 12;
   localparam int QW = 4;
   localparam int WW = 4;

   logic          clk = 1'b0;
   logic          rst;
   logic          fv_raw;
   logic          resync_en;
   logic [QW-1:0] cfg_qual;
   logic [WW-1:0] cfg_window;
   logic [CW-1:0] cfg_act_px, cfg_hblank, cfg_act_ln, cfg_vblank;
   logic          fv_out, lv_out, px_en, armed, edge_miss;

   always #2 clk = ~clk;

   vid_timing_regen #(.CNT_W(CW), .QUAL_W(QW), .WIN_W(WW)) u_dut (
      .clk(clk), .rst(rst), .fv_raw(fv_raw), .resync_en(resync_en),
      .cfg_qual(cfg_qual), .cfg_window(cfg_window),
      .cfg_act_px(cfg_act_px), .cfg_hblank(cfg_hblank),
      .cfg_act_ln(cfg_act_ln), .cfg_vblank(cfg_vblank),
      .fv_out(fv_out), .lv_out(lv_out), .px_en(px_en),
      .armed(armed), .edge_miss(edge_miss)
   );

   int    checks = 0, errors = 0, cyc = 0, miss_seen = 0;
   bit    cmp_on = 0, done = 0;
   string phase = "R1";

   // Behavioural reference state
   int m_s1, m_s2, m_hi, m_run, m_h, m_v, m_miss;
   int l_px, l_hb, l_ln, l_vb;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin : ref_model
      int acc, win, hl, vl;
      hl  = l_hb + l_px - 1;
      vl  = l_ln + l_vb - 1;
      acc = (m_s2 != 0 && m_hi == int'(cfg_qual)) ? 1 : 0;
      win = (((l_vb != 0) && (m_v == vl) && (m_h + int'(cfg_window) >= hl)) ||
             ((m_v == 0) && (m_h < int'(cfg_window)) && (m_h < l_hb))) ? 1 : 0;
      if (rst) begin
         m_s1 = 0; m_s2 = 0; m_hi = 0; m_run = 0; m_h = 0; m_v = 0; m_miss = 0;
         l_px = 0; l_hb = 0; l_ln = 0; l_vb = 0;
      end else begin
         m_miss = (m_run != 0 && acc != 0 && win == 0) ? 1 : 0;
         if (acc != 0 && (m_run == 0 || (resync_en && win != 0)) ||
             (m_run != 0 && m_h == hl && m_v == vl)) begin
            m_run = 1; m_h = 0; m_v = 0;
            l_px = int'(cfg_act_px); l_hb = int'(cfg_hblank);
            l_ln = int'(cfg_act_ln); l_vb = int'(cfg_vblank);
         end else if (m_run != 0) begin
            if (m_h == hl) begin m_h = 0; m_v++; end
            else m_h++;
         end
         if (m_s2 == 0) m_hi = 0;
         else if (m_hi < (1 << (QW + 1)) - 1) m_hi++;
         m_s2 = m_s1;
         m_s1 = fv_raw ? 1 : 0;
      end
   end

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         int efv, elv;
         efv = (m_run != 0 && m_v < l_ln) ? 1 : 0;
         elv = (efv != 0 && m_h >= l_hb) ? 1 : 0;
         chk(armed == m_run[0],    {"R2 armed ", phase}, armed, m_run);
         chk(fv_out == efv[0],     {"R5 fv_out ", phase}, fv_out, efv);
         chk(lv_out == elv[0],     {"R4 lv_out ", phase}, lv_out, elv);
         chk(px_en == elv[0],      {"R4 px_en ", phase}, px_en, elv);
         chk(edge_miss == m_miss[0], {"R9 edge_miss ", phase}, edge_miss, m_miss);
         chk(!(lv_out && !fv_out), {"R10 lv without fv ", phase}, lv_out, 0);
         if (edge_miss) miss_seen++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // Fire one accepted edge so that it is processed at frame position pt.
   task automatic shot(input int pt);
      int f, tgt;
      f   = (l_hb + l_px) * (l_ln + l_vb);
      tgt = ((pt - int'(cfg_qual) - 2) % f + f) % f;
      for (int k = 0; k < 2 * f; k++) begin
         @(negedge clk);
         if (m_v * (l_hb + l_px) + m_h == tgt) break;
      end
      fv_raw = 1'b1;
      repeat (int'(cfg_qual) + 3) @(negedge clk);
      fv_raw = 1'b0;
      repeat (f + 5) @(negedge clk);
   endtask

   initial begin
      int m0;
      rst = 1'b1; fv_raw = 1'b0; resync_en = 1'b0;
      cfg_qual = 4'd2; cfg_window = 4'd3;
      cfg_act_px = 12'd6; cfg_hblank = 12'd4; cfg_act_ln = 12'd3; cfg_vblank = 12'd2;
      repeat (2) @(negedge clk);
      cmp_on = 1;
      @(negedge clk);
      chk(!armed && !fv_out && !lv_out, "R1 reset state", armed, 0);
      rst = 1'b0;

      // R3: pulses too short to qualify
      phase = "R3";
      repeat (3) @(negedge clk);
      fv_raw = 1'b1; @(negedge clk); fv_raw = 1'b0;
      repeat (6) @(negedge clk);
      fv_raw = 1'b1; repeat (2) @(negedge clk); fv_raw = 1'b0;
      repeat (8) @(negedge clk);
      chk(!armed, "R3 short pulses leave block unarmed", armed, 0);

      // R2: a qualified edge arms
      phase = "R2";
      fv_raw = 1'b1;
      repeat (5) @(negedge clk);
      chk(armed, "R2 qualified edge arms", armed, 1);
      repeat (20) @(negedge clk);
      fv_raw = 1'b0;

      // R7: heavy glitching with resync off
      phase = "R7";
      for (int i = 0; i < 160; i++) begin
         fv_raw = (((i * 37) % 11) < 5);
         @(negedge clk);
      end
      fv_raw = 1'b0;
      repeat (10) @(negedge clk);

      // R6: mid-frame configuration change
      phase = "R6";
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (m_run != 0 && m_v == 1) break;
      end
      cfg_act_px = 12'd5; cfg_act_ln = 12'd4;
      repeat (130) @(negedge clk);

      // R8: resync shots; frame is now 9 clocks x 6 lines
      phase = "R8";
      resync_en = 1'b1;
      m0 = miss_seen;
      shot(51);   // early, inside window
      shot(1);    // late, inside window
      shot(53);   // exactly on time
      chk(miss_seen == m0, "R8 in-window edges raise no miss", miss_seen - m0, 0);
      m0 = miss_seen;
      phase = "R9";
      shot(20);   // outside window
      chk(miss_seen - m0 == 1, "R9 out-of-window edge flagged once", miss_seen - m0, 1);

      // R1: reset while running
      phase = "R1";
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(!armed && !fv_out && !lv_out && !edge_miss, "R1 reset while running", armed, 0);
      rst = 1'b0;
      repeat (5) @(negedge clk);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule